// File: doc/BRIEF.md
# Replay Trigger Selector and Qualifier

This block turns a set of trigger sources into one internal trigger strobe for a pattern replay engine. Four kinds of source feed it:
- an external trigger line, armed on either its rising or its falling edge;
- a software strobe;
- six backplane trigger lines, each enabled on its own;
- a star trigger line.

Every source has an enable. Any enabled source that fires produces the strobe, which lasts one clock, but only while the block is armed.

The external line is asynchronous, as are the backplane lines and the star line. Each passes through a two-flop synchroniser. The external line also goes through a width filter. An external edge counts only when the line then stays at its active level for more than two sample clocks, so short glitches are rejected. Each accepted external pulse produces exactly one trigger, however long the pulse lasts.

A trigger output pin can be enabled. When it is, the first internal trigger in each armed period drives the pin high for a fixed number of clocks, so that external equipment can start in step with the replay.

Top module: `trq_replay_trigger`

## Requirements
- R1: With the rising edge selected (`ext_fall_i`=0) and `ext_en_i`=1, the external line goes from low to high and stays high for 3 clock samples. This gives one `trig_pulse_o`, 5 clock edges after the first edge that samples the line high.
- R2: With `ext_fall_i`=1, the active level of the external line is low. A high-to-low transition held for 3 or more samples gives exactly one trigger.
- R3: A one-cycle `sw_strobe_i` with `sw_en_i`=1 gives `trig_pulse_o` in the following cycle. With `sw_en_i`=0 the strobe has no effect.
- R4: A rising edge on backplane line i (bit i of `bus_trig_i`) gives a trigger 3 edges after it is first sampled, but only when bit i of `bus_en_i` is 1. The enabled lines are ORed, and lines that are not enabled are ignored.
- R5: A rising edge on `star_trig_i` gives a trigger when `star_en_i`=1, with the same 3-edge latency. It has no effect when `star_en_i`=0.
- R6: An external pulse that holds its active level for 2 samples or fewer gives no trigger.
- R7: An external pulse gives at most one trigger, however long it stays active.
- R8: No `trig_pulse_o` is produced in the cycle after a cycle with `arm_i`=0.
- R9: With `tout_en_i`=1, the first internal trigger of an armed period drives `trig_out_o` high for exactly OUT_HOLD clocks (default 4), starting one clock after `trig_pulse_o`. Later triggers in the same armed period cause no further rising edge. Dropping `arm_i` for a cycle re-enables the output.
- R10: With `tout_en_i`=0, `trig_out_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Block armed; gates the internal trigger |
| ext_trig_i | input | 1 | Asynchronous external trigger line |
| ext_fall_i | input | 1 | 0: rising edge active, 1: falling edge active |
| ext_en_i | input | 1 | External source enable |
| sw_strobe_i | input | 1 | Synchronous software trigger strobe |
| sw_en_i | input | 1 | Software source enable |
| bus_trig_i | input | 6 | Asynchronous backplane trigger lines |
| bus_en_i | input | 6 | Per-line enable for the backplane lines |
| star_trig_i | input | 1 | Asynchronous star trigger line |
| star_en_i | input | 1 | Star source enable |
| tout_en_i | input | 1 | Trigger output enable |
| trig_pulse_o | output | 1 | One-cycle internal trigger to the replay engine |
| trig_out_o | output | 1 | Stretched trigger output pin |

## Verification
External pulses of 2 and 3 samples check the boundary of the width filter. A long held pulse checks that each pulse fires only once. A falling-edge pulse checks the polarity selection.

The backplane lines are exercised with one enabled line, with a disabled line, and with a pair of enabled lines, which tells the per-line enables apart from the OR. The software and star sources are each tried with their enable set and with it cleared. Their measured latencies distinguish the synchronised paths from the direct path.

A burst of triggers inside one armed period, then a re-arm, shows that the output pin gives a single stretched pulse per armed period. The same trigger with the output disabled shows the pin stays low.

// File: rtl/trq_pkg.sv
package trq_pkg;
  localparam int unsigned TRQ_BUS_LINES   = 6;
  localparam int unsigned TRQ_SYNC_STAGES = 2;
  localparam int unsigned TRQ_EXT_MIN_PER = 2;
  localparam int unsigned TRQ_OUT_HOLD    = 4;

  typedef enum logic {
    TRQ_EDGE_RISE = 1'b0,
    TRQ_EDGE_FALL = 1'b1
  } trq_edge_e;
endpackage

// File: rtl/trq_sync.sv
module trq_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q[0] <= '0;
    end else begin
      stage_q[0] <= async_i;
    end
  end

  genvar s;
  generate
    for (s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else begin
          stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/trq_edge.sv
module trq_edge #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl_i,
  input  logic [WIDTH-1:0] en_i,
  output logic             hit_o
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= lvl_i;
    end
  end

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_line
      assign rise[i] = lvl_i[i] & ~prev_q[i] & en_i[i];
    end
  endgenerate

  assign hit_o = |rise;

  // R4: a hit needs an enabled line that was low one cycle earlier and is high now
  p_edge_needs_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> ((lvl_i & en_i & ~prev_q) != '0));
endmodule

// File: rtl/trq_ext_qual.sv
module trq_ext_qual #(
  parameter int unsigned MIN_PERIODS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic fall_sel_i,
  output logic fire_o
);
  import trq_pkg::*;

  localparam int unsigned NEED  = MIN_PERIODS + 1;
  localparam int unsigned CNT_W = $clog2(NEED + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NEED - 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(NEED);

  logic             active;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             idle_q, idle_n;
  trq_edge_e        pol;

  assign pol    = trq_edge_e'(fall_sel_i);
  assign active = (pol == TRQ_EDGE_FALL) ? ~lvl_i : lvl_i;

  always_comb begin
    cnt_n  = cnt_q;
    idle_n = idle_q;
    if (!active) begin
      cnt_n  = '0;
      idle_n = 1'b1;
    end else if (idle_q && (cnt_q != CNT_SAT)) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      idle_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      idle_q <= idle_n;
    end
  end

  assign fire_o = active && idle_q && (cnt_q == CNT_LAST);

  // R6: a qualified edge has held its active level on three consecutive samples
  p_ext_min_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> (active && $past(active) && $past(active, 2)));

  // R7: one qualified event per pulse
  p_ext_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o);
endmodule

// File: rtl/trq_out_stretch.sv
module trq_out_stretch #(
  parameter int unsigned HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic out_en_i,
  input  logic trig_i,
  output logic pin_o
);
  localparam int unsigned CNT_W = $clog2(HOLD + 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             done_q, done_n;
  logic             pin_q, pin_n;
  logic             start;

  assign start = trig_i && out_en_i && !done_q;

  always_comb begin
    cnt_n  = cnt_q;
    done_n = done_q;
    if (!arm_i) begin
      done_n = 1'b0;
    end
    if (start) begin
      cnt_n  = CNT_W'(HOLD);
      done_n = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_n = cnt_q - 1'b1;
    end
    pin_n = (cnt_n != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      done_q <= done_n;
      pin_q  <= pin_n;
    end
  end

  assign pin_o = pin_q;

  // R10: the pin only starts after an enabled trigger
  p_out_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_o) |-> ($past(out_en_i) && $past(trig_i)));

  // R9: the pin stays high past its first cycle
  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_o) |=> pin_o);
endmodule

// File: rtl/trq_replay_trigger.sv
module trq_replay_trigger #(
  parameter int unsigned BUS_LINES   = trq_pkg::TRQ_BUS_LINES,
  parameter int unsigned SYNC_STAGES = trq_pkg::TRQ_SYNC_STAGES,
  parameter int unsigned EXT_MIN_PER = trq_pkg::TRQ_EXT_MIN_PER,
  parameter int unsigned OUT_HOLD    = trq_pkg::TRQ_OUT_HOLD
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arm_i,
  input  logic                 ext_trig_i,
  input  logic                 ext_fall_i,
  input  logic                 ext_en_i,
  input  logic                 sw_strobe_i,
  input  logic                 sw_en_i,
  input  logic [BUS_LINES-1:0] bus_trig_i,
  input  logic [BUS_LINES-1:0] bus_en_i,
  input  logic                 star_trig_i,
  input  logic                 star_en_i,
  input  logic                 tout_en_i,
  output logic                 trig_pulse_o,
  output logic                 trig_out_o
);
  localparam int unsigned ASYNC_W = BUS_LINES + 2;

  logic [ASYNC_W-1:0] async_raw, async_sync;
  logic               ext_lvl, star_lvl;
  logic [BUS_LINES-1:0] bus_lvl;
  logic               ext_fire, bus_hit, star_hit, sw_hit;
  logic               any_fire;
  logic               trig_q, trig_n;

  assign async_raw = {star_trig_i, bus_trig_i, ext_trig_i};

  trq_sync #(.WIDTH(ASYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (async_raw),
    .sync_o  (async_sync)
  );

  assign ext_lvl  = async_sync[0];
  assign bus_lvl  = async_sync[BUS_LINES:1];
  assign star_lvl = async_sync[ASYNC_W-1];

  trq_ext_qual #(.MIN_PERIODS(EXT_MIN_PER)) u_ext (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl_i      (ext_lvl),
    .fall_sel_i (ext_fall_i),
    .fire_o     (ext_fire)
  );

  trq_edge #(.WIDTH(BUS_LINES)) u_bus (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (bus_lvl),
    .en_i  (bus_en_i),
    .hit_o (bus_hit)
  );

  trq_edge #(.WIDTH(1)) u_star (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (star_lvl),
    .en_i  (star_en_i),
    .hit_o (star_hit)
  );

  assign sw_hit   = sw_strobe_i & sw_en_i;
  assign any_fire = (ext_fire & ext_en_i) | bus_hit | star_hit | sw_hit;

  always_comb begin
    trig_n = arm_i & any_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
    end else begin
      trig_q <= trig_n;
    end
  end

  assign trig_pulse_o = trig_q;

  trq_out_stretch #(.HOLD(OUT_HOLD)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_i    (arm_i),
    .out_en_i (tout_en_i),
    .trig_i   (trig_q),
    .pin_o    (trig_out_o)
  );

  // R8: nothing fires out of an unarmed cycle
  p_no_trig_unarmed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_i |=> !trig_pulse_o);

  // R3: an enabled software strobe while armed reaches the output next cycle
  p_sw_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_strobe_i && sw_en_i && arm_i) |=> trig_pulse_o);
endmodule

// File: tb/trq_replay_trigger_tb_top.sv
module trq_replay_trigger_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       arm_i, ext_trig_i, ext_fall_i, ext_en_i;
  logic       sw_strobe_i, sw_en_i, star_trig_i, star_en_i, tout_en_i;
  logic [5:0] bus_trig_i, bus_en_i;
  logic       trig_pulse_o, trig_out_o;

  int n_chk = 0;
  int n_fail = 0;
  int pulse_cnt, first_lat, win_cyc, out_rises, out_high;
  logic out_prev;
  bit finished = 0;

  always #10 clk = ~clk;

  trq_replay_trigger dut_i (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i),
    .ext_trig_i(ext_trig_i), .ext_fall_i(ext_fall_i), .ext_en_i(ext_en_i),
    .sw_strobe_i(sw_strobe_i), .sw_en_i(sw_en_i),
    .bus_trig_i(bus_trig_i), .bus_en_i(bus_en_i),
    .star_trig_i(star_trig_i), .star_en_i(star_en_i),
    .tout_en_i(tout_en_i),
    .trig_pulse_o(trig_pulse_o), .trig_out_o(trig_out_o)
  );

  always @(negedge clk) begin
    win_cyc = win_cyc + 1;
    if (trig_pulse_o) begin
      pulse_cnt = pulse_cnt + 1;
      if (first_lat < 0) first_lat = win_cyc;
    end
    if (trig_out_o) out_high = out_high + 1;
    if (trig_out_o && !out_prev) out_rises = out_rises + 1;
    out_prev = trig_out_o;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic open_window();
    @(posedge clk);
    pulse_cnt = 0; first_lat = -1; win_cyc = 0; out_rises = 0; out_high = 0;
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ext_pulse(input int len, input logic act_lvl);
    @(negedge clk); ext_trig_i = act_lvl;
    wait_neg(len);  ext_trig_i = ~act_lvl;
  endtask

  task automatic sw_pulse();
    @(negedge clk); sw_strobe_i = 1'b1;
    @(negedge clk); sw_strobe_i = 1'b0;
  endtask

  task automatic t_reset();
    check(trig_pulse_o == 1'b0, "R8 reset pulse", trig_pulse_o, 0);
    check(trig_out_o == 1'b0, "R10 reset out", trig_out_o, 0);
  endtask

  task automatic t_ext_rise();
    ext_en_i = 1'b1;
    open_window(); ext_pulse(3, 1'b1); wait_neg(12);
    check(pulse_cnt == 1, "R1 count", pulse_cnt, 1);
    check(first_lat == 6, "R1 latency", first_lat, 6);
    open_window(); ext_pulse(2, 1'b1); wait_neg(12);
    check(pulse_cnt == 0, "R6 two-sample pulse", pulse_cnt, 0);
    open_window(); ext_pulse(1, 1'b1); wait_neg(12);
    check(pulse_cnt == 0, "R6 one-sample pulse", pulse_cnt, 0);
    open_window(); ext_pulse(20, 1'b1); wait_neg(12);
    check(pulse_cnt == 1, "R7 long pulse", pulse_cnt, 1);
    ext_en_i = 1'b0;
  endtask

  task automatic t_ext_fall();
    @(negedge clk); ext_trig_i = 1'b1; wait_neg(6);
    ext_fall_i = 1'b1; wait_neg(6);
    ext_en_i = 1'b1;
    open_window(); ext_pulse(3, 1'b0); wait_neg(12);
    check(pulse_cnt == 1, "R2 falling pulse", pulse_cnt, 1);
    open_window(); ext_pulse(2, 1'b0); wait_neg(12);
    check(pulse_cnt == 0, "R2 short falling pulse", pulse_cnt, 0);
    ext_en_i = 1'b0; ext_fall_i = 1'b0;
    @(negedge clk); ext_trig_i = 1'b0; wait_neg(6);
  endtask

  task automatic t_sw();
    sw_en_i = 1'b1;
    open_window(); sw_pulse(); wait_neg(4);
    check(pulse_cnt == 1, "R3 strobe", pulse_cnt, 1);
    check(first_lat == 2, "R3 latency", first_lat, 2);
    sw_en_i = 1'b0;
    open_window(); sw_pulse(); wait_neg(4);
    check(pulse_cnt == 0, "R3 disabled strobe", pulse_cnt, 0);
  endtask

  task automatic bus_pulse(input int line);
    @(negedge clk); bus_trig_i[line] = 1'b1;
    wait_neg(4); bus_trig_i[line] = 1'b0;
  endtask

  task automatic t_bus();
    bus_en_i = 6'b001000;
    open_window(); bus_pulse(3); wait_neg(6);
    check(pulse_cnt == 1, "R4 line3", pulse_cnt, 1);
    check(first_lat == 4, "R4 latency", first_lat, 4);
    open_window(); bus_pulse(1); wait_neg(6);
    check(pulse_cnt == 0, "R4 disabled line1", pulse_cnt, 0);
    bus_en_i = 6'b100001;
    open_window(); bus_pulse(5); wait_neg(6); bus_pulse(0); wait_neg(6);
    check(pulse_cnt == 2, "R4 lines 0 and 5", pulse_cnt, 2);
    bus_en_i = 6'b000000;
  endtask

  task automatic t_star();
    star_en_i = 1'b1;
    open_window();
    @(negedge clk); star_trig_i = 1'b1; wait_neg(4); star_trig_i = 1'b0; wait_neg(6);
    check(pulse_cnt == 1, "R5 star", pulse_cnt, 1);
    check(first_lat == 4, "R5 latency", first_lat, 4);
    star_en_i = 1'b0;
    open_window();
    @(negedge clk); star_trig_i = 1'b1; wait_neg(4); star_trig_i = 1'b0; wait_neg(6);
    check(pulse_cnt == 0, "R5 star disabled", pulse_cnt, 0);
  endtask

  task automatic t_arm();
    sw_en_i = 1'b1; arm_i = 1'b0;
    open_window(); sw_pulse(); wait_neg(4);
    check(pulse_cnt == 0, "R8 unarmed", pulse_cnt, 0);
    arm_i = 1'b1; sw_en_i = 1'b0;
  endtask

  task automatic t_out();
    sw_en_i = 1'b1; tout_en_i = 1'b1;
    @(negedge clk); arm_i = 1'b0; @(negedge clk); arm_i = 1'b1;
    open_window(); sw_pulse(); wait_neg(2); sw_pulse(); wait_neg(8); sw_pulse(); wait_neg(8);
    check(pulse_cnt == 3, "R9 three triggers", pulse_cnt, 3);
    check(out_rises == 1, "R9 single out edge", out_rises, 1);
    check(out_high == 4, "R9 out width", out_high, 4);
    @(negedge clk); arm_i = 1'b0; @(negedge clk); arm_i = 1'b1;
    open_window(); sw_pulse(); wait_neg(8);
    check(out_rises == 1, "R9 re-armed out", out_rises, 1);
    tout_en_i = 1'b0;
    @(negedge clk); arm_i = 1'b0; @(negedge clk); arm_i = 1'b1;
    open_window(); sw_pulse(); wait_neg(8);
    check(pulse_cnt == 1 && out_high == 0, "R10 out disabled", out_high, 0);
    sw_en_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; arm_i = 1'b1; ext_trig_i = 1'b0; ext_fall_i = 1'b0; ext_en_i = 1'b0;
    sw_strobe_i = 1'b0; sw_en_i = 1'b0; bus_trig_i = '0; bus_en_i = '0;
    star_trig_i = 1'b0; star_en_i = 1'b0; tout_en_i = 1'b0;
    out_prev = 1'b0; pulse_cnt = 0; first_lat = -1; win_cyc = 0; out_rises = 0; out_high = 0;
    wait_neg(3);
    t_reset();
    rst_n = 1'b1;
    wait_neg(4);
    t_ext_rise();
    t_ext_fall();
    t_sw();
    t_bus();
    t_star();
    t_arm();
    t_out();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule